// File: doc/BRIEF.md
# Bus Bandwidth Monitor

This peripheral counts the bytes that bus transactions move through one master port. Each accepted transfer beat adds its byte count to a counter. The counter can be read at any time. The count is compared against a programmable limit. Two events can be flagged: reaching the limit, and carry-out of the counter's top bit. Software reads and clears both flags through a small register bus. It also enables a per-monitor interrupt line.

A set of global registers holds one bit per master port. This instance implements only the bit whose position equals its elaboration-time port number. That bit drives a global status output, and a global enable gates a second interrupt output. Two further registers are plain storage for transaction filter settings. Those settings do not change counting in this block.

A parameter selects one of two behaviours at the limit. In wrap mode, the counter returns to zero each time the limit is reached. In free-running mode, the counter keeps counting past the limit and rolls over modulo 2^32, which flags an overflow.

Top module: `bwm_monitor`

## Requirements
- R1: After a synchronous reset, the following registers read 0: control (0x00), count (0x08), status (0x10), interrupt enable (0x18) and global status (0x30). The limit register (0x0C) reads 0xFFFFFFFF. All three interrupt and status outputs are low.
- R2: Control bit 0 enables counting, and bits 20:16 hold a 5-bit throttle setting. Both fields read back from 0x00. The throttle field keeps its value when bit 0 is cleared. Beats offered while bit 0 is clear leave the count unchanged.
- R3: A write to 0x04 with bit 0 set zeroes the counter. A beat offered in the same cycle is dropped.
- R4: Register 0x08 reads the live counter, which is the sum of all accepted beat byte counts. In free-running mode, a carry out of bit 31 wraps the counter modulo 2^32 and sets status bit 1.
- R5: In free-running mode, status bit 0 sets on the beat that takes the count from below the limit to at or above it. It does not set again while the count stays at or above the limit.
- R6: In wrap mode, a beat whose sum reaches the limit zeroes the counter and sets status bit 0. Status bit 1 never sets in this mode.
- R7: Writing to 0x14 clears each status bit whose write-data bit is 1. A flag event in the same cycle as its clear leaves the bit set.
- R8: The interrupt output is high exactly when interrupt-enable bit 0 (0x18) is set and a status bit is pending. It changes on the same clock edge as either input.
- R9: Global status bit PORT_ID (read at 0x30, also on the global status output) sets on any local flag event. It is cleared only by writing 1 to bit PORT_ID of 0x34. The global interrupt output is that bit ANDed with bit PORT_ID of the global enable register (0x38).
- R10: The filter mask register (0x1C) and filter value register (0x20) read back what was written. They have no effect on the count.
- R11: Read data is registered. It is valid the cycle after the read strobe and holds until the next read. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | DW | Register write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | DW | Registered read data |
| beat_bytes | input | BEAT_W | Byte count of the current transfer beat |
| beat_valid | input | 1 | Qualifies beat_bytes |
| irq_o | output | 1 | Per-monitor interrupt |
| glb_stat_o | output | 1 | Global status bit of this port |
| glb_irq_o | output | 1 | Global interrupt of this port |

## Verification
Every beat and every register write takes effect on the next rising edge. This applies to the counter, both status flags, the global bit and both interrupt outputs, with no further pipeline stage. Read data arrives one edge after the read strobe. The bench drives all inputs on falling edges. It checks the interrupt pins at the falling edge that follows the updating edge. A scoreboard queue holds the expected read results. They are compared at the falling edge after the edge that captured the read. Two instances receive identical traffic, one in each counting mode, so that every wrap-versus-overflow difference shows up on the same stimulus.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
  localparam int AW = 8;
  localparam int THR_LSB = 16;
  localparam int THR_W = 5;

  localparam logic [AW-1:0] OFS_CTRL  = 8'h00;
  localparam logic [AW-1:0] OFS_CLR   = 8'h04;
  localparam logic [AW-1:0] OFS_COUNT = 8'h08;
  localparam logic [AW-1:0] OFS_LIMIT = 8'h0C;
  localparam logic [AW-1:0] OFS_STAT  = 8'h10;
  localparam logic [AW-1:0] OFS_ACK   = 8'h14;
  localparam logic [AW-1:0] OFS_IEN   = 8'h18;
  localparam logic [AW-1:0] OFS_FMASK = 8'h1C;
  localparam logic [AW-1:0] OFS_FVAL  = 8'h20;
  localparam logic [AW-1:0] OFS_GSTAT = 8'h30;
  localparam logic [AW-1:0] OFS_GACK  = 8'h34;
  localparam logic [AW-1:0] OFS_GEN   = 8'h38;
endpackage

// File: rtl/bwm_regs.sv
module bwm_regs
  import bwm_pkg::*;
#(
  parameter int DW      = 32,
  parameter int PORT_ID = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          we,
  input  logic          re,
  input  logic [DW-1:0] cnt_i,
  input  logic [1:0]    stat_i,
  input  logic          ien_i,
  input  logic          gen_i,
  input  logic          gflag_i,
  output logic          en_o,
  output logic [DW-1:0] limit_o,
  output logic          clr_o,
  output logic [1:0]    ack_o,
  output logic          ien_we_o,
  output logic          gen_we_o,
  output logic          gack_o,
  output logic [DW-1:0] rdata_o
);
  logic             en_q;
  logic [THR_W-1:0] thr_q;
  logic [DW-1:0]    limit_q;
  logic [DW-1:0]    fmask_q;
  logic [DW-1:0]    fval_q;
  logic [DW-1:0]    rdata_q;
  logic [DW-1:0]    rd_mux;

  // Write-side decode of the pulse-type registers
  assign clr_o    = we && (addr == OFS_CLR) && wdata[0];
  assign ack_o    = (we && (addr == OFS_ACK)) ? wdata[1:0] : 2'b00;
  assign ien_we_o = we && (addr == OFS_IEN);
  assign gen_we_o = we && (addr == OFS_GEN);
  assign gack_o   = we && (addr == OFS_GACK) && wdata[PORT_ID];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      thr_q   <= '0;
      limit_q <= '1;
      fmask_q <= '0;
      fval_q  <= '0;
    end else if (we) begin
      case (addr)
        OFS_CTRL: begin
          en_q  <= wdata[0];
          thr_q <= wdata[THR_LSB +: THR_W];
        end
        OFS_LIMIT: limit_q <= wdata;
        OFS_FMASK: fmask_q <= wdata;
        OFS_FVAL:  fval_q  <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      OFS_CTRL: begin
        rd_mux[0] = en_q;
        rd_mux[THR_LSB +: THR_W] = thr_q;
      end
      OFS_COUNT: rd_mux = cnt_i;
      OFS_LIMIT: rd_mux = limit_q;
      OFS_STAT:  rd_mux[1:0] = stat_i;
      OFS_IEN:   rd_mux[0] = ien_i;
      OFS_FMASK: rd_mux = fmask_q;
      OFS_FVAL:  rd_mux = fval_q;
      OFS_GSTAT: rd_mux[PORT_ID] = gflag_i;
      OFS_GEN:   rd_mux[PORT_ID] = gen_i;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (re) rdata_q <= rd_mux;
  end

  assign en_o    = en_q;
  assign limit_o = limit_q;
  assign rdata_o = rdata_q;

  // R11: read data only moves on a read strobe
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(rdata_q));
endmodule

// File: rtl/bwm_counter.sv
module bwm_counter #(
  parameter int DW     = 32,
  parameter int BW     = 16,
  parameter bit WRAP   = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          clr_i,
  input  logic          vld_i,
  input  logic [BW-1:0] bytes_i,
  input  logic [DW-1:0] limit_i,
  output logic [DW-1:0] cnt_o,
  output logic          thr_evt_o,
  output logic          ovf_evt_o
);
  localparam int PAD = DW + 1 - BW;

  logic [DW-1:0] cnt_q;
  logic [DW-1:0] cnt_d;
  logic [DW:0]   sum;
  logic          take;
  logic          reach;

  assign take  = en_i && vld_i && !clr_i;
  assign sum   = {1'b0, cnt_q} + {{PAD{1'b0}}, bytes_i};
  assign reach = sum >= {1'b0, limit_i};

  generate
    if (WRAP) begin : g_wrap
      assign cnt_d     = reach ? '0 : sum[DW-1:0];
      assign thr_evt_o = take && reach;
      assign ovf_evt_o = 1'b0;

      // R6: reaching the limit leaves the counter at zero
      p_wrap_zero_r6: assert property (@(posedge clk) disable iff (rst)
        thr_evt_o |=> (cnt_q == '0));
    end else begin : g_free
      assign cnt_d     = sum[DW-1:0];
      assign thr_evt_o = take && reach && (cnt_q < limit_i);
      assign ovf_evt_o = take && sum[DW];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_q <= '0;
    else if (take)    cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R3: a clear leaves the counter at zero
  p_clr_zero_r3: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_q == '0));
  // R2: no movement while counting is disabled
  p_hold_off_r2: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/bwm_irq.sv
module bwm_irq (
  input  logic       clk,
  input  logic       rst,
  input  logic       thr_evt_i,
  input  logic       ovf_evt_i,
  input  logic [1:0] ack_i,
  input  logic       ien_we_i,
  input  logic       ien_bit_i,
  input  logic       gen_we_i,
  input  logic       gen_bit_i,
  input  logic       gack_i,
  output logic [1:0] stat_o,
  output logic       ien_o,
  output logic       gen_o,
  output logic       gflag_o,
  output logic       irq_o,
  output logic       girq_o
);
  logic [1:0] stat_q, stat_d;
  logic       ien_q, ien_d;
  logic       gen_q, gen_d;
  logic       gflag_q, gflag_d;
  logic       irq_q, girq_q;

  // Event wins over a same-cycle clear
  assign stat_d  = (stat_q & ~ack_i) | {ovf_evt_i, thr_evt_i};
  assign ien_d   = ien_we_i ? ien_bit_i : ien_q;
  assign gen_d   = gen_we_i ? gen_bit_i : gen_q;
  assign gflag_d = (gflag_q & ~gack_i) | thr_evt_i | ovf_evt_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q  <= '0;
      ien_q   <= 1'b0;
      gen_q   <= 1'b0;
      gflag_q <= 1'b0;
      irq_q   <= 1'b0;
      girq_q  <= 1'b0;
    end else begin
      stat_q  <= stat_d;
      ien_q   <= ien_d;
      gen_q   <= gen_d;
      gflag_q <= gflag_d;
      irq_q   <= ien_d & (|stat_d);
      girq_q  <= gen_d & gflag_d;
    end
  end

  assign stat_o  = stat_q;
  assign ien_o   = ien_q;
  assign gen_o   = gen_q;
  assign gflag_o = gflag_q;
  assign irq_o   = irq_q;
  assign girq_o  = girq_q;

  // R7: a threshold event is never lost to a clear
  p_stat_set_r7: assert property (@(posedge clk) disable iff (rst)
    thr_evt_i |=> stat_q[0]);
  // R7: clear without competing event drops the flag
  p_ack_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (ack_i[0] && !thr_evt_i) |=> !stat_q[0]);
  // R8: interrupt line tracks enable and pending status
  p_irq_match_r8: assert property (@(posedge clk) disable iff (rst)
    irq_q == (ien_q & (|stat_q)));
  // R9: global bit follows any local event
  p_gflag_set_r9: assert property (@(posedge clk) disable iff (rst)
    (thr_evt_i || ovf_evt_i) |=> gflag_q);
endmodule

// File: rtl/bwm_monitor.sv
module bwm_monitor
  import bwm_pkg::*;
#(
  parameter int DW            = 32,
  parameter int BEAT_W        = 16,
  parameter int PORT_ID       = 3,
  parameter bit WRAP_ON_LIMIT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic              reg_we,
  input  logic              reg_re,
  output logic [DW-1:0]     reg_rdata,
  input  logic [BEAT_W-1:0] beat_bytes,
  input  logic              beat_valid,
  output logic              irq_o,
  output logic              glb_stat_o,
  output logic              glb_irq_o
);
  logic          en, clr, ien_we, gen_we, gack, ien, gen, gflag;
  logic          thr_evt, ovf_evt;
  logic [1:0]    ack, stat;
  logic [DW-1:0] limit, cnt;

  bwm_regs #(.DW(DW), .PORT_ID(PORT_ID)) u_regs (
    .clk(clk), .rst(rst), .addr(reg_addr), .wdata(reg_wdata),
    .we(reg_we), .re(reg_re), .cnt_i(cnt), .stat_i(stat),
    .ien_i(ien), .gen_i(gen), .gflag_i(gflag), .en_o(en),
    .limit_o(limit), .clr_o(clr), .ack_o(ack), .ien_we_o(ien_we),
    .gen_we_o(gen_we), .gack_o(gack), .rdata_o(reg_rdata)
  );

  bwm_counter #(.DW(DW), .BW(BEAT_W), .WRAP(WRAP_ON_LIMIT)) u_cnt (
    .clk(clk), .rst(rst), .en_i(en), .clr_i(clr), .vld_i(beat_valid),
    .bytes_i(beat_bytes), .limit_i(limit), .cnt_o(cnt),
    .thr_evt_o(thr_evt), .ovf_evt_o(ovf_evt)
  );

  bwm_irq u_irq (
    .clk(clk), .rst(rst), .thr_evt_i(thr_evt), .ovf_evt_i(ovf_evt),
    .ack_i(ack), .ien_we_i(ien_we), .ien_bit_i(reg_wdata[0]),
    .gen_we_i(gen_we), .gen_bit_i(reg_wdata[PORT_ID]), .gack_i(gack),
    .stat_o(stat), .ien_o(ien), .gen_o(gen), .gflag_o(gflag),
    .irq_o(irq_o), .girq_o(glb_irq_o)
  );

  assign glb_stat_o = gflag;
endmodule

// File: tb/bwm_monitor_bench.sv
`timescale 1ns/1ps
module bwm_monitor_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0, re = 1'b0, re_d = 1'b0;
  logic [31:0] bytes = '0;
  logic        vld = 1'b0;
  logic [31:0] rdata_a, rdata_b;
  logic        irq_a, irq_b, gs_a, gs_b, gi_a, gi_b;

  int tests = 0;
  int fails = 0;

  logic [31:0] exp_a_q[$];
  logic [31:0] exp_b_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  bwm_monitor #(.BEAT_W(32), .PORT_ID(3), .WRAP_ON_LIMIT(1'b0)) u_bwm_monitor (
    .clk(clk), .rst(rst), .reg_addr(addr), .reg_wdata(wdata), .reg_we(we),
    .reg_re(re), .reg_rdata(rdata_a), .beat_bytes(bytes), .beat_valid(vld),
    .irq_o(irq_a), .glb_stat_o(gs_a), .glb_irq_o(gi_a)
  );

  bwm_monitor #(.BEAT_W(32), .PORT_ID(3), .WRAP_ON_LIMIT(1'b1)) u_bwm_monitor_wrap (
    .clk(clk), .rst(rst), .reg_addr(addr), .reg_wdata(wdata), .reg_we(we),
    .reg_re(re), .reg_rdata(rdata_b), .beat_bytes(bytes), .beat_valid(vld),
    .irq_o(irq_b), .glb_stat_o(gs_b), .glb_irq_o(gi_b)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic beat(input logic [31:0] b);
    @(negedge clk); bytes = b; vld = 1'b1;
    @(negedge clk); vld = 1'b0;
  endtask

  task automatic wr_beat(input logic [7:0] a, input logic [31:0] d, input logic [31:0] b);
    @(negedge clk); addr = a; wdata = d; we = 1'b1; bytes = b; vld = 1'b1;
    @(negedge clk); we = 1'b0; vld = 1'b0;
  endtask

  // Driver: issue read, push expected values for both instances
  task automatic rd(input logic [7:0] a, input logic [31:0] ea,
                    input logic [31:0] eb, input string tag);
    @(negedge clk); addr = a; re = 1'b1;
    exp_a_q.push_back(ea); exp_b_q.push_back(eb); tag_q.push_back(tag);
    @(negedge clk); re = 1'b0;
  endtask

  always @(posedge clk) re_d <= re;

  // Monitor: read data is valid at the falling edge after the capture edge
  always @(negedge clk) begin
    if (re_d) begin
      if (tag_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R11 unexpected read data actual=%h expected=none", rdata_a);
      end else begin
        string t;
        logic [31:0] ea, eb;
        t = tag_q.pop_front(); ea = exp_a_q.pop_front(); eb = exp_b_q.pop_front();
        chk({t, " free"}, rdata_a, ea);
        chk({t, " wrap"}, rdata_b, eb);
      end
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R11 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq free", irq_a, 0); chk("R1 irq wrap", irq_b, 0);
    chk("R1 gstat", gs_a, 0); chk("R1 girq", gi_a, 0);
    rd(8'h00, 0, 0, "R1 ctrl");
    rd(8'h08, 0, 0, "R1 count");
    rd(8'h0C, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1 limit");
    rd(8'h10, 0, 0, "R1 status");
    rd(8'h30, 0, 0, "R1 gstat reg");
    // R2 disabled beats ignored
    beat(100);
    rd(8'h08, 0, 0, "R2 disabled count");
    wr(8'h00, 32'h0005_0001);
    rd(8'h00, 32'h0005_0001, 32'h0005_0001, "R2 ctrl readback");
    wr(8'h0C, 1000);
    // R4 accumulation
    beat(300); beat(300);
    rd(8'h08, 600, 600, "R4 count");
    rd(8'h10, 0, 0, "R5 below limit");
    // R5/R6 reaching the limit
    beat(400);
    chk("R8 irq off while disabled", irq_a, 0);
    chk("R9 gstat free", gs_a, 1); chk("R9 gstat wrap", gs_b, 1);
    chk("R9 girq gated", gi_a, 0);
    rd(8'h08, 1000, 0, "R6 count at limit");
    rd(8'h10, 1, 1, "R5 threshold flag");
    wr(8'h18, 1);
    chk("R8 irq free", irq_a, 1); chk("R8 irq wrap", irq_b, 1);
    rd(8'h18, 1, 1, "R8 ien readback");
    rd(8'h30, 32'h8, 32'h8, "R9 gstat bit position");
    wr(8'h38, 32'h8);
    chk("R9 girq enabled", gi_a, 1);
    wr(8'h34, 32'h4);
    chk("R9 foreign ack ignored", gs_a, 1);
    wr(8'h34, 32'h8);
    chk("R9 own ack clears", gs_a, 0); chk("R9 girq low", gi_a, 0);
    // R7 write-one-to-clear
    wr(8'h14, 32'h2);
    rd(8'h10, 1, 1, "R7 other bit kept");
    wr(8'h14, 32'h1);
    rd(8'h10, 0, 0, "R7 cleared");
    chk("R8 irq drops", irq_a, 0);
    // R5 no re-trigger above limit
    beat(100);
    rd(8'h08, 1100, 100, "R5 count above");
    rd(8'h10, 0, 0, "R5 no second flag");
    // R7 set wins over same-cycle clear (wrap instance reaches limit)
    wr_beat(8'h14, 32'h1, 900);
    rd(8'h10, 0, 1, "R7 set beats clear");
    chk("R8 irq wrap set", irq_b, 1); chk("R8 irq free clear", irq_a, 0);
    wr(8'h14, 32'h3);
    // R3 clear drops concurrent beat
    wr_beat(8'h04, 32'h1, 50);
    rd(8'h08, 0, 0, "R3 clear with beat");
    // R2 throttle retained while disabled
    wr(8'h00, 32'h0005_0000);
    rd(8'h00, 32'h0005_0000, 32'h0005_0000, "R2 throttle kept");
    beat(70);
    rd(8'h08, 0, 0, "R2 beat while off");
    wr(8'h00, 32'h1);
    // R10 filter storage
    wr(8'h1C, 32'hDEAD_BEEF); wr(8'h20, 32'h1234_5678);
    rd(8'h1C, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R10 mask");
    rd(8'h20, 32'h1234_5678, 32'h1234_5678, "R10 value");
    beat(70);
    rd(8'h08, 70, 70, "R10 counting unaffected");
    rd(8'h40, 0, 0, "R11 unmapped");
    // R4 overflow vs R6 wrap
    wr(8'h04, 1); wr(8'h0C, 32'hFFFF_FFFF);
    beat(32'hFFFF_FF00);
    rd(8'h08, 32'hFFFF_FF00, 32'hFFFF_FF00, "R4 near top");
    beat(32'h200);
    rd(8'h08, 32'h100, 0, "R4 rollover count");
    rd(8'h10, 3, 1, "R4 overflow flag / R6 none");
    chk("R8 irq on overflow", irq_a, 1);
    repeat (3) @(negedge clk);
    if (tag_q.size() != 0) begin
      tests++; fails++;
      $display("FAIL R11 reads pending actual=%0d expected=0", tag_q.size());
    end
    finish_run();
  end
endmodule